// File: doc/BRIEF.md
# Bit-Granular Field Reader

This block reads fields of arbitrary bit alignment out of a byte-addressed memory. It holds a byte pointer and a bit offset inside that byte. A data read fetches three consecutive bytes from memory through a request/acknowledge port and forms a 24-bit little-endian window from them. The window is shifted right by the bit offset, and the two lowest bytes of the result are returned through a low and a high data register.

After each field is consumed, the pointer steps forward by a programmable field length of 1 to 16 bits. In step-on-write mode, the step happens when the length/mode register is written. In step-on-read mode, the step happens as a side effect of reading the high data register, after the returned value has been formed. A decoder reads a stream by setting the start address once and then either re-writing the length for each field or reading the high register repeatedly.

The host side is a simple register bus with one select field. Writes complete in the cycle they are presented. Data reads hold `bus_ready` low until the three memory bytes have arrived.

Top module: `bitstream_reader`

## Requirements
- R1: After reset the byte pointer is 0, the bit offset is 0, the mode is step-on-write and the length code is 0.
- R2: Writes to selects 0, 1 and 2 load bits 7:0, 15:8 and 23:16 of the byte pointer. A write to select 2 also clears the bit offset to 0.
- R3: A read of select 4 returns bits 7:0, and a read of select 5 returns bits 15:8, of ({m[p+2], m[p+1], m[p]} >> offset), where p is the byte pointer.
- R4: In the length/mode register (select 3), bits 3:0 give the field length, and a code of 0 means 16 bits.
- R5: A write to select 3 with bit 7 = 0 selects step-on-write mode and steps the pointer once by the newly written length.
- R6: With bit 7 = 1 (step-on-read mode), each read of select 5 steps the pointer after its data is formed. A read of select 4 never changes the position.
- R7: In step-on-write mode, data reads never change the position.
- R8: A step adds the length to the offset, adds bits 4:3 of that sum to the byte pointer modulo 2^24, and keeps bits 2:0 as the new offset.
- R9: A data read keeps `bus_ready` low until exactly three memory bytes have been fetched, at p, p+1 and p+2 in that order. The address stays stable while a request is waiting for its acknowledge.
- R10: A write completes with `bus_ready` high in the same cycle. Writes to selects 4 to 7 have no effect on the position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Host access request, held until `bus_ready` |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_sel | input | 3 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while `bus_ready` is high |
| bus_ready | output | 1 | Access completes in this cycle |
| mem_req | output | 1 | Memory byte request |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_rdata | input | 8 | Memory byte, valid with `mem_ack` |
| mem_ack | input | 1 | Memory byte delivered |

## Verification
The bench builds the block with the default 24-bit pointer, so wrap-around is checked at the real modulus. Start addresses placed just below 2^24 make the three-byte fetch and the step cross the top of the address space. Random lengths including code 0, mixed with both modes, drive the offset through every value from 0 to 7 and produce byte carries of 0, 1 and 2. The bench memory answers each request one cycle later, which keeps the stall visible for several cycles on every data read.

// File: rtl/bitstream_reader.sv
module bitstream_reader #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [2:0]        bus_sel,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              bus_ready,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_ack
);
  localparam logic [2:0] SEL_A0 = 3'd0, SEL_A1 = 3'd1, SEL_A2 = 3'd2,
                         SEL_LEN = 3'd3, SEL_LO = 3'd4, SEL_HI = 3'd5;
  localparam int HI_W = ADDR_W - 16;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_DONE} state_t;

  state_t              state;
  logic [ADDR_W-1:0]   ptr;
  logic [2:0]          off;
  logic                auto_mode;
  logic [3:0]          len_code;
  logic [23:0]         win;
  logic [1:0]          idx;
  logic                rd_hi;

  function automatic logic [4:0] len5(input logic [3:0] c);
    return (c == 4'd0) ? 5'd16 : {1'b0, c};
  endfunction

  logic [4:0]  sum_w, sum_c;
  logic [23:0] shifted;
  logic        is_data, accept;

  assign sum_w   = {2'b00, off} + len5(bus_wdata[3:0]);
  assign sum_c   = {2'b00, off} + len5(len_code);
  assign shifted = win >> off;
  assign is_data = (bus_sel == SEL_LO) || (bus_sel == SEL_HI);
  assign accept  = (state == S_IDLE) && bus_valid;

  assign bus_ready = (accept && (bus_write || !is_data)) || (state == S_DONE);
  assign bus_rdata = (state == S_DONE) ? (rd_hi ? shifted[15:8] : shifted[7:0]) : 8'h00;
  assign mem_req   = (state == S_FETCH);
  assign mem_addr  = ptr + ADDR_W'(idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      ptr       <= '0;
      off       <= '0;
      auto_mode <= 1'b0;
      len_code  <= '0;
      win       <= '0;
      idx       <= '0;
      rd_hi     <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (bus_valid) begin
          if (bus_write) begin
            case (bus_sel)
              SEL_A0: ptr[7:0]  <= bus_wdata;
              SEL_A1: ptr[15:8] <= bus_wdata;
              SEL_A2: begin
                ptr[ADDR_W-1:16] <= bus_wdata[HI_W-1:0];
                off <= '0;
              end
              SEL_LEN: begin
                auto_mode <= bus_wdata[7];
                len_code  <= bus_wdata[3:0];
                if (!bus_wdata[7]) begin
                  ptr <= ptr + ADDR_W'(sum_w[4:3]);
                  off <= sum_w[2:0];
                end
              end
              default: ;
            endcase
          end else if (is_data) begin
            state <= S_FETCH;
            idx   <= '0;
            rd_hi <= (bus_sel == SEL_HI);
          end
        end
        S_FETCH: if (mem_ack) begin
          win <= {mem_rdata, win[23:8]};
          idx <= idx + 2'd1;
          if (idx == 2'd2) state <= S_DONE;
        end
        default: begin
          state <= S_IDLE;
          if (rd_hi && auto_mode) begin
            ptr <= ptr + ADDR_W'(sum_c[4:3]);
            off <= sum_c[2:0];
          end
        end
      endcase
    end
  end

  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !bus_ready);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
  p_offclr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && bus_write && bus_sel == SEL_A2) |=> (off == 3'd0));
  p_lowread_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DONE && !rd_hi) |=> ($stable(ptr) && $stable(off)));
  p_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DONE && !auto_mode) |=> ($stable(ptr) && $stable(off)));
  p_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DONE && rd_hi && auto_mode) |=> ((ptr - $past(ptr)) <= ADDR_W'(2)));
endmodule

// File: tb/tb_bitstream_reader.sv
module tb_bitstream_reader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [2:0]  bus_sel = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        bus_ready;
  logic        mem_req;
  logic [23:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic        mem_ack;

  int tests = 0, fails = 0, acks = 0;
  logic [23:0] ack_addr [0:2];
  logic [23:0] m_addr = '0;
  logic [2:0]  m_off = '0;
  logic        m_auto = 1'b0;
  logic [3:0]  m_len = '0;

  always #5 clk = ~clk;

  bitstream_reader #(.ADDR_W(24)) dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack));

  function automatic logic [7:0] mb(input logic [23:0] a);
    return (a[7:0] * 8'd29) ^ (a[15:8] * 8'd7) ^ a[23:16] ^ 8'hA5;
  endfunction

  function automatic logic [23:0] expect_word();
    logic [23:0] w;
    w = {mb(m_addr + 24'd2), mb(m_addr + 24'd1), mb(m_addr)};
    return w >> m_off;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      mem_rdata <= '0;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      mem_rdata <= mb(mem_addr);
      if (mem_req && !mem_ack) begin
        if (acks < 3) ack_addr[acks] <= mem_addr;
        acks <= acks + 1;
      end
    end
  end

  task automatic chk(input string req, input logic ok, input int got, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic m_step(input logic [3:0] c);
    int s;
    s = int'(m_off) + ((c == 4'd0) ? 16 : int'(c));
    m_addr = m_addr + 24'(s >> 3);
    m_off = 3'(s & 7);
  endtask

  task automatic access(input logic wr, input logic [2:0] sel, input logic [7:0] d,
                        output logic [7:0] q, output int waits);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_sel = sel; bus_wdata = d;
    waits = 0;
    #1;
    while (!bus_ready) begin
      @(negedge clk); #1;
      waits++;
    end
    q = bus_rdata;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d, input string req);
    logic [7:0] q; int w;
    access(1'b1, sel, d, q, w);
    chk(req, w == 0, w, 0);
  endtask

  task automatic set_addr(input logic [23:0] a);
    wr(3'd0, a[7:0], "R2");
    wr(3'd1, a[15:8], "R2");
    wr(3'd2, a[23:16], "R2");
    m_addr = a; m_off = '0;
  endtask

  task automatic set_len(input logic mode, input logic [3:0] c);
    wr(3'd3, {mode, 3'b000, c}, "R10");
    m_auto = mode; m_len = c;
    if (!mode) m_step(c);
  endtask

  task automatic rd(input logic hi, input string req);
    logic [7:0] q; int w; logic [23:0] e; int a0;
    e = expect_word();
    a0 = acks;
    access(1'b0, hi ? 3'd5 : 3'd4, 8'h00, q, w);
    chk(req, q == (hi ? e[15:8] : e[7:0]), q, hi ? e[15:8] : e[7:0]);
    chk("R9", (acks - a0) == 3 && w >= 3, acks - a0, 3);
    if (hi && m_auto) m_step(m_len);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset position and step-on-write mode
    rd(1'b0, "R1");
    rd(1'b1, "R1");
    rd(1'b0, "R7");
    // R9 address order
    begin
      int a0;
      logic [7:0] q; int w;
      a0 = acks;
      access(1'b0, 3'd4, 8'h00, q, w);
      @(negedge clk);
      chk("R9", ack_addr[0] == 24'd0 || a0 != 0, int'(ack_addr[0]), 0);
    end
    // R2 / R3
    set_addr(24'h12_3456);
    rd(1'b0, "R3"); rd(1'b1, "R3");
    set_len(1'b0, 4'd5);
    rd(1'b0, "R5"); rd(1'b1, "R3");
    set_addr(24'h12_3456);
    rd(1'b0, "R2");
    // R4: code 0 means 16 bits
    set_len(1'b0, 4'd3);
    set_len(1'b0, 4'd0);
    rd(1'b0, "R4"); rd(1'b1, "R4");
    // R6: step-on-read
    set_len(1'b1, 4'd7);
    rd(1'b0, "R6"); rd(1'b0, "R6");
    rd(1'b1, "R6"); rd(1'b0, "R6");
    rd(1'b1, "R6"); rd(1'b1, "R6"); rd(1'b0, "R6");
    // R10: writes to data selects ignored
    wr(3'd4, 8'hFF, "R10"); wr(3'd5, 8'h3C, "R10"); wr(3'd7, 8'h81, "R10");
    rd(1'b0, "R10");
    // R8: wrap modulo 2^24
    set_addr(24'hFF_FFFE);
    rd(1'b0, "R8"); rd(1'b1, "R8");
    set_len(1'b0, 4'd0);
    rd(1'b0, "R8");
    set_len(1'b1, 4'd15);
    rd(1'b1, "R8"); rd(1'b0, "R8");
    // random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      op = int'($urandom % 7);
      case (op)
        0: set_addr(($urandom % 4 == 0) ? (24'hFF_FFF0 | 24'($urandom % 16)) : 24'($urandom));
        1: set_len(1'($urandom), 4'($urandom));
        2: wr(3'd4 + 3'($urandom % 4), 8'($urandom), "R10");
        3, 4: rd(1'b1, m_auto ? "R6" : "R7");
        default: rd(1'b0, "R8");
      endcase
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule